// File: doc/BRIEF.md
# Legacy Display Window Decoder with Register-Page Overlap

This block sits between a CPU memory bus and a display controller's video memory. It decides whether a memory cycle falls inside the legacy display aperture and, if it does, where the cycle goes. A two-bit window select chooses the aperture: a 128 KB window at A0000, a 64 KB window at A0000, a 32 KB window at B0000, or a 32 KB window at B8000. A hit inside the aperture is masked to the window size. Address bit 15 then chooses one of two bank offsets, and the low 15 bits are added to that offset to form the video-memory byte address. When any of the four linear-mode bits is set, the legacy decoder is switched off.

A 256-byte accelerator register page can be enabled at B8000. A byte in that page goes to the register-file port, whatever video window is selected. When the video window is also at B8000, an overlap flag is raised. An access that begins in the register page but runs past its end then continues into video memory. Without the overlap flag, those bytes read as all ones and their writes are dropped. Reads of the register page return 0x00 at the status offset 0x40 and 0xFF at every other offset.

Each CPU access carries up to LANES byte lanes, and the block splits it into byte cycles, one per lane, in ascending address order. Read data is reassembled little-endian and returned with a one-cycle completion pulse.

Top module: `lgw_window_decoder`

## Requirements
- R1: With window select 2'b00, byte addresses A0000 to BFFFF hit video memory, masked with 0xFFFF. Masked bit 15 = 1 selects `bank1_off`, and 0 selects `bank0_off`.
- R2: Window select 2'b01 hits A0000 to AFFFF with mask 0xFFFF. 2'b10 hits B0000 to B7FFF with mask 0x7FFF. 2'b11 hits B8000 to BFFFF with mask 0x7FFF.
- R3: When any bit of `cfg_lin_mode` is nonzero, `legacy_active` is low. In that state no video or register strobe is issued, every read lane returns 0xFF and writes have no effect.
- R4: When `cfg_mmio_en` is 1 and the legacy decoder is active, a byte whose address bits [19:8] equal 12'hB80 goes to the register port with `rf_off` = address bits [7:0]. This holds for every window select, and that byte never goes to video memory.
- R5: A register-page read returns 8'h00 at offset 8'h40 and 8'hFF at any other offset.
- R6: `ovl_flag` is 1 in the cycle after the legacy decoder is active with window select 2'b11. It is 0 in the cycle after any other setting.
- R7: If an access's base address lies in the enabled register page, its lanes outside that page go to video memory only when `ovl_flag` is 1. Otherwise they read 0xFF and issue no strobe, even if the address lies inside the video window.
- R8: The video address is (masked address bits [14:0], zero-extended) plus the bank offset chosen by masked bit 15.
- R9: Lane i uses byte address `cpu_addr`+i and write byte `cpu_wdata[8i+7:8i]`, and returns its read byte in `cpu_rdata[8i+7:8i]`. Lanes are issued in ascending order. A lane whose `cpu_be` bit is 0 issues no strobe and reads 0xFF.
- R10: A byte outside the selected window and outside the register page issues no strobe and reads 0xFF.
- R11: An accepted request drops `cpu_ready` for LANES+1 cycles. `cpu_done` then pulses for one cycle, as `cpu_ready` returns, and `cpu_rdata` is valid in that cycle.
- R12: After reset, `cpu_ready` is 1, `cpu_done` is 0, `ovl_flag` is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_map_sel | input | 2 | Legacy window select |
| cfg_lin_mode | input | 4 | Linear-mode bits; any set disables the legacy decoder |
| cfg_mmio_en | input | 1 | Register-page enable |
| bank0_off | input | VADDR_W | Bank offset used when masked bit 15 is 0 |
| bank1_off | input | VADDR_W | Bank offset used when masked bit 15 is 1 |
| cpu_req | input | 1 | Access request, taken when cpu_ready is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 20 | Byte address of lane 0 |
| cpu_be | input | LANES | Lane enables |
| cpu_wdata | input | 8*LANES | Write data, little-endian |
| cpu_ready | output | 1 | Idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8*LANES | Reassembled read data |
| vm_stb | output | 1 | Video-memory byte cycle |
| vm_we | output | 1 | Video-memory write |
| vm_addr | output | VADDR_W | Banked video byte address |
| vm_wdata | output | 8 | Video write byte |
| vm_rdata | input | 8 | Video read byte, one cycle after vm_stb |
| rf_stb | output | 1 | Register-page byte cycle |
| rf_we | output | 1 | Register-page write |
| rf_off | output | 8 | Register offset |
| rf_wdata | output | 8 | Register write byte |
| legacy_active | output | 1 | Legacy decoder enabled |
| ovl_flag | output | 1 | Register page overlaps the video window |

## Verification
The bench builds the block with LANES = 4 and VADDR_W = 20. Four lanes make a dword that starts at B80FE straddle the end of the register page, so both the overlap fall-through and the all-ones path can be reached. The 20-bit video address keeps the two bank offsets, 0x10000 and 0x24000, apart, so a wrong bank choice shows up in the logged strobe address. The bench's video model returns address-derived bytes one cycle late. That makes reassembly order, lane placement and the read-capture timing all visible in `cpu_rdata`.

// File: rtl/lgw_pkg.sv
`timescale 1ns/1ps
package lgw_pkg;

  // CPU byte-address width of the legacy aperture space
  localparam int ADDR_W = 20;
  // Width of the in-window offset after masking
  localparam int WOFF_W = 16;
  // Bits of in-window offset forwarded beside the bank offset
  localparam int BANK_LOW_W = 15;
  // Register page base (address bits [19:8])
  localparam logic [ADDR_W-9:0] REG_PAGE = 12'hB80;
  // Status register offset inside the page
  localparam logic [7:0] STATUS_OFF = 8'h40;
  // Fill value for unmapped and register reads
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    WIN_128K_A0 = 2'b00,
    WIN_64K_A0  = 2'b01,
    WIN_32K_B0  = 2'b10,
    WIN_32K_B8  = 2'b11
  } win_sel_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_VRAM = 2'd1,
    TGT_REG  = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_DRAIN = 2'd2
  } seq_state_e;

endpackage

// File: rtl/lgw_map_decode.sv
`timescale 1ns/1ps
module lgw_map_decode
  import lgw_pkg::*;
(
  input  logic [1:0]        map_sel,
  input  logic              legacy,
  input  logic              mmio_en,
  input  logic              ovl,
  input  logic              claimed,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [WOFF_W-1:0] win_off,
  output logic [7:0]        reg_rbyte
);

  logic              in_win;
  logic              in_page;
  logic [WOFF_W-1:0] mask;
  win_sel_e          sel;

  assign sel = win_sel_e'(map_sel);

  // window hit and size mask from the select field
  always_comb begin
    in_win = 1'b0;
    mask   = 16'hFFFF;
    unique case (sel)
      WIN_128K_A0: begin
        in_win = (addr[19:17] == 3'b101);
        mask   = 16'hFFFF;
      end
      WIN_64K_A0: begin
        in_win = (addr[19:16] == 4'hA);
        mask   = 16'hFFFF;
      end
      WIN_32K_B0: begin
        in_win = (addr[19:15] == 5'b10110);
        mask   = 16'h7FFF;
      end
      WIN_32K_B8: begin
        in_win = (addr[19:15] == 5'b10111);
        mask   = 16'h7FFF;
      end
      default: begin
        in_win = 1'b0;
        mask   = 16'hFFFF;
      end
    endcase
  end

  assign in_page = legacy && mmio_en && (addr[ADDR_W-1:8] == REG_PAGE);
  assign win_off = addr[WOFF_W-1:0] & mask;

  // routing priority: register page, then page-claimed spill, then window
  always_comb begin
    if (in_page) begin
      tgt = TGT_REG;
    end else if (claimed) begin
      tgt = (ovl && legacy && in_win) ? TGT_VRAM : TGT_NONE;
    end else if (legacy && in_win) begin
      tgt = TGT_VRAM;
    end else begin
      tgt = TGT_NONE;
    end
  end

  assign reg_rbyte = (addr[7:0] == STATUS_OFF) ? 8'h00 : FILL_BYTE;

endmodule

// File: rtl/lgw_bank_xlate.sv
`timescale 1ns/1ps
module lgw_bank_xlate
  import lgw_pkg::*;
#(
  parameter int VADDR_W = 22
) (
  input  logic [WOFF_W-1:0]  win_off,
  input  logic [VADDR_W-1:0] bank0,
  input  logic [VADDR_W-1:0] bank1,
  output logic [VADDR_W-1:0] vaddr
);

  localparam int PAD_W = (VADDR_W > BANK_LOW_W) ? VADDR_W - BANK_LOW_W : 1;

  logic [VADDR_W-1:0] low_ext;
  logic [VADDR_W-1:0] bank_sel;

  generate
    if (VADDR_W > BANK_LOW_W) begin : g_pad
      assign low_ext = {{PAD_W{1'b0}}, win_off[BANK_LOW_W-1:0]};
    end else if (VADDR_W == BANK_LOW_W) begin : g_exact
      assign low_ext = win_off[BANK_LOW_W-1:0];
    end else begin : g_trunc
      assign low_ext = win_off[VADDR_W-1:0];
    end
  endgenerate

  assign bank_sel = win_off[BANK_LOW_W] ? bank1 : bank0;
  assign vaddr    = low_ext + bank_sel;

endmodule

// File: rtl/lgw_byte_seq.sv
`timescale 1ns/1ps
module lgw_byte_seq
  import lgw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LANES-1:0]     be,
  input  logic [8*LANES-1:0]   wdata,
  input  logic                 start_claim,
  output logic                 ready,
  output logic                 done,
  output logic [8*LANES-1:0]   rdata,
  output logic [ADDR_W-1:0]    lane_addr,
  output logic                 lane_en,
  output logic                 lane_we,
  output logic [7:0]           lane_wbyte,
  output logic                 lane_claim,
  input  tgt_e                 tgt,
  input  logic [7:0]           reg_rbyte,
  input  logic [7:0]           vm_rbyte
);

  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  seq_state_e           state_q;
  logic [LANE_W-1:0]    lane_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [LANES-1:0]     be_q;
  logic [8*LANES-1:0]   wdata_q;
  logic                 we_q;
  logic                 claim_q;
  logic [8*LANES-1:0]   rdata_q;
  logic                 pend_q;
  logic [LANE_W-1:0]    pend_lane_q;
  logic                 done_q;
  logic                 accept;
  logic                 rd_vm;
  logic                 rd_reg;

  assign accept     = (state_q == SQ_IDLE) && req;
  assign lane_addr  = addr_q + ADDR_W'(lane_q);
  assign lane_en    = (state_q == SQ_ISSUE) && be_q[lane_q];
  assign lane_we    = we_q;
  assign lane_wbyte = wdata_q[{lane_q, 3'b000} +: 8];
  assign lane_claim = claim_q;
  assign rd_vm      = lane_en && !we_q && (tgt == TGT_VRAM);
  assign rd_reg     = lane_en && !we_q && (tgt == TGT_REG);

  // control path
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      lane_q  <= '0;
      done_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pend_q <= rd_vm;
      unique case (state_q)
        SQ_IDLE: begin
          lane_q <= '0;
          if (accept) state_q <= SQ_ISSUE;
        end
        SQ_ISSUE: begin
          if (lane_q == LAST_LANE) begin
            state_q <= SQ_DRAIN;
          end else begin
            lane_q <= lane_q + 1'b1;
          end
        end
        SQ_DRAIN: begin
          state_q <= SQ_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      claim_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr;
      be_q    <= be;
      wdata_q <= wdata;
      we_q    <= we;
      claim_q <= start_claim;
    end
  end

  // read reassembly: register bytes land at issue, video bytes one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q     <= {LANES{FILL_BYTE}};
      pend_lane_q <= '0;
    end else begin
      if (accept) begin
        rdata_q <= {LANES{FILL_BYTE}};
      end else begin
        if (rd_reg) rdata_q[{lane_q, 3'b000} +: 8] <= reg_rbyte;
        if (pend_q) rdata_q[{pend_lane_q, 3'b000} +: 8] <= vm_rbyte;
      end
      if (rd_vm) pend_lane_q <= lane_q;
    end
  end

  assign ready = (state_q == SQ_IDLE);
  assign done  = done_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/lgw_window_decoder.sv
`timescale 1ns/1ps
module lgw_window_decoder
  import lgw_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int VADDR_W = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           cfg_map_sel,
  input  logic [3:0]           cfg_lin_mode,
  input  logic                 cfg_mmio_en,
  input  logic [VADDR_W-1:0]   bank0_off,
  input  logic [VADDR_W-1:0]   bank1_off,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [19:0]          cpu_addr,
  input  logic [LANES-1:0]     cpu_be,
  input  logic [8*LANES-1:0]   cpu_wdata,
  output logic                 cpu_ready,
  output logic                 cpu_done,
  output logic [8*LANES-1:0]   cpu_rdata,
  output logic                 vm_stb,
  output logic                 vm_we,
  output logic [VADDR_W-1:0]   vm_addr,
  output logic [7:0]           vm_wdata,
  input  logic [7:0]           vm_rdata,
  output logic                 rf_stb,
  output logic                 rf_we,
  output logic [7:0]           rf_off,
  output logic [7:0]           rf_wdata,
  output logic                 legacy_active,
  output logic                 ovl_flag
);

  logic              legacy;
  logic              ovl_q;
  logic              start_claim;
  logic [ADDR_W-1:0] lane_addr;
  logic              lane_en;
  logic              lane_we;
  logic [7:0]        lane_wbyte;
  logic              lane_claim;
  tgt_e              tgt;
  logic [WOFF_W-1:0] win_off;
  logic [7:0]        reg_rbyte;

  assign legacy      = ~|cfg_lin_mode;
  assign start_claim = legacy && cfg_mmio_en && (cpu_addr[ADDR_W-1:8] == REG_PAGE);

  // overlap flag re-evaluated from the live map every cycle
  always_ff @(posedge clk) begin
    if (rst) ovl_q <= 1'b0;
    else     ovl_q <= legacy && (win_sel_e'(cfg_map_sel) == WIN_32K_B8);
  end

  lgw_byte_seq #(
    .LANES(LANES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req         (cpu_req),
    .we          (cpu_we),
    .addr        (cpu_addr),
    .be          (cpu_be),
    .wdata       (cpu_wdata),
    .start_claim (start_claim),
    .ready       (cpu_ready),
    .done        (cpu_done),
    .rdata       (cpu_rdata),
    .lane_addr   (lane_addr),
    .lane_en     (lane_en),
    .lane_we     (lane_we),
    .lane_wbyte  (lane_wbyte),
    .lane_claim  (lane_claim),
    .tgt         (tgt),
    .reg_rbyte   (reg_rbyte),
    .vm_rbyte    (vm_rdata)
  );

  lgw_map_decode u_dec (
    .map_sel   (cfg_map_sel),
    .legacy    (legacy),
    .mmio_en   (cfg_mmio_en),
    .ovl       (ovl_q),
    .claimed   (lane_claim),
    .addr      (lane_addr),
    .tgt       (tgt),
    .win_off   (win_off),
    .reg_rbyte (reg_rbyte)
  );

  lgw_bank_xlate #(
    .VADDR_W(VADDR_W)
  ) u_xlate (
    .win_off (win_off),
    .bank0   (bank0_off),
    .bank1   (bank1_off),
    .vaddr   (vm_addr)
  );

  assign vm_stb        = lane_en && (tgt == TGT_VRAM);
  assign vm_we         = vm_stb && lane_we;
  assign vm_wdata      = lane_wbyte;
  assign rf_stb        = lane_en && (tgt == TGT_REG);
  assign rf_we         = rf_stb && lane_we;
  assign rf_off        = lane_addr[7:0];
  assign rf_wdata      = lane_wbyte;
  assign legacy_active = legacy;
  assign ovl_flag      = ovl_q;

endmodule

// File: rtl/lgw_window_decoder_chk.sv
`timescale 1ns/1ps
module lgw_window_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_map_sel,
  input logic [3:0] cfg_lin_mode,
  input logic       cfg_mmio_en,
  input logic       cpu_req,
  input logic       cpu_ready,
  input logic       cpu_done,
  input logic       vm_stb,
  input logic       rf_stb,
  input logic       legacy_active,
  input logic       ovl_flag
);

  p_linear_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_lin_mode != 4'h0) |-> (!vm_stb && !rf_stb && !legacy_active));

  p_reg_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
    rf_stb |-> (cfg_mmio_en && legacy_active));

  p_single_target_r4: assert property (@(posedge clk) disable iff (rst)
    !(vm_stb && rf_stb));

  p_ovl_tracks_map_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ovl_flag == $past(cfg_map_sel == 2'b11 && cfg_lin_mode == 4'h0)));

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> !cpu_ready);

  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (!vm_stb && !rf_stb));

endmodule

bind lgw_window_decoder lgw_window_decoder_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_map_sel   (cfg_map_sel),
  .cfg_lin_mode  (cfg_lin_mode),
  .cfg_mmio_en   (cfg_mmio_en),
  .cpu_req       (cpu_req),
  .cpu_ready     (cpu_ready),
  .cpu_done      (cpu_done),
  .vm_stb        (vm_stb),
  .rf_stb        (rf_stb),
  .legacy_active (legacy_active),
  .ovl_flag      (ovl_flag)
);

// File: tb/lgw_window_decoder_bench.sv
`timescale 1ns/1ps
module lgw_window_decoder_bench;

  localparam int LANES   = 4;
  localparam int VADDR_W = 20;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [1:0]           cfg_map_sel = 2'b00;
  logic [3:0]           cfg_lin_mode = 4'h0;
  logic                 cfg_mmio_en = 1'b0;
  logic [VADDR_W-1:0]   bank0_off = 20'h10000;
  logic [VADDR_W-1:0]   bank1_off = 20'h24000;
  logic                 cpu_req = 1'b0;
  logic                 cpu_we = 1'b0;
  logic [19:0]          cpu_addr = '0;
  logic [LANES-1:0]     cpu_be = '0;
  logic [8*LANES-1:0]   cpu_wdata = '0;
  logic                 cpu_ready;
  logic                 cpu_done;
  logic [8*LANES-1:0]   cpu_rdata;
  logic                 vm_stb;
  logic                 vm_we;
  logic [VADDR_W-1:0]   vm_addr;
  logic [7:0]           vm_wdata;
  logic [7:0]           vm_rdata = 8'h00;
  logic                 rf_stb;
  logic                 rf_we;
  logic [7:0]           rf_off;
  logic [7:0]           rf_wdata;
  logic                 legacy_active;
  logic                 ovl_flag;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lgw_window_decoder #(.LANES(LANES), .VADDR_W(VADDR_W)) u_lgw_window_decoder (
    .clk(clk), .rst(rst), .cfg_map_sel(cfg_map_sel), .cfg_lin_mode(cfg_lin_mode),
    .cfg_mmio_en(cfg_mmio_en), .bank0_off(bank0_off), .bank1_off(bank1_off),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .vm_stb(vm_stb), .vm_we(vm_we), .vm_addr(vm_addr),
    .vm_wdata(vm_wdata), .vm_rdata(vm_rdata), .rf_stb(rf_stb), .rf_we(rf_we),
    .rf_off(rf_off), .rf_wdata(rf_wdata), .legacy_active(legacy_active),
    .ovl_flag(ovl_flag)
  );

  // video memory model: read byte is address-derived, one cycle late
  always @(posedge clk) vm_rdata <= (vm_stb && !vm_we) ? (vm_addr[7:0] ^ 8'hC3) : 8'h00;

  // strobe logs
  logic [19:0] vm_la [0:63];
  logic [7:0]  vm_ld [0:63];
  logic        vm_lw [0:63];
  logic [7:0]  rf_lo [0:63];
  logic [7:0]  rf_ld [0:63];
  logic        rf_lw [0:63];
  int vm_n = 0;
  int rf_n = 0;

  always @(posedge clk) begin
    if (vm_stb) begin
      vm_la[vm_n % 64] <= vm_addr;
      vm_ld[vm_n % 64] <= vm_wdata;
      vm_lw[vm_n % 64] <= vm_we;
      vm_n <= vm_n + 1;
    end
    if (rf_stb) begin
      rf_lo[rf_n % 64] <= rf_off;
      rf_ld[rf_n % 64] <= rf_wdata;
      rf_lw[rf_n % 64] <= rf_we;
      rf_n <= rf_n + 1;
    end
  end

  int vm_base, rf_base, last_busy, last_wait;
  logic [31:0] last_rd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [3:0] lin, input logic en);
    @(negedge clk);
    cfg_map_sel  = m;
    cfg_lin_mode = lin;
    cfg_mmio_en  = en;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access(input logic we, input logic [19:0] a, input logic [3:0] be,
                        input logic [31:0] wd);
    @(negedge clk);
    vm_base = vm_n;
    rf_base = rf_n;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    last_busy = 0;
    last_wait = -1;
    for (int i = 0; i < 20; i++) begin
      if (cpu_done) begin
        last_wait = i;
        break;
      end
      if (!cpu_ready) last_busy++;
      @(negedge clk);
    end
    last_rd = cpu_rdata;
    chk("R11 busy cycles", last_busy, LANES + 1);
    chk("R11 done position", last_wait, LANES + 1);
    chk("R11 ready with done", {31'd0, cpu_ready}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R12 ready after reset", {31'd0, cpu_ready}, 32'd1);
    chk("R12 done after reset", {31'd0, cpu_done}, 32'd0);
    chk("R12 ovl after reset", {31'd0, ovl_flag}, 32'd0);
    chk("R12 no strobes", {30'd0, vm_stb, rf_stb}, 32'd0);
  endtask

  task automatic t_map128();
    set_cfg(2'b00, 4'h0, 1'b0);
    access(1'b1, 20'hA8000, 4'hF, 32'h44332211);
    chk("R9 vm write count", vm_n - vm_base, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R1 R8 bank1 address", {12'd0, vm_la[(vm_base + i) % 64]}, 32'h24000 + i);
      chk("R9 lane write byte", {24'd0, vm_ld[(vm_base + i) % 64]}, 32'h11 * (i + 1));
      chk("R9 write flag", {31'd0, vm_lw[(vm_base + i) % 64]}, 32'd1);
    end
    access(1'b0, 20'hB0004, 4'b0011, 32'h0);
    chk("R9 vm read count", vm_n - vm_base, 2);
    chk("R1 R8 bank0 address", {12'd0, vm_la[vm_base % 64]}, 32'h10004);
    chk("R9 partial read data", last_rd, 32'hFFFFC6C7);
  endtask

  task automatic t_map64();
    set_cfg(2'b01, 4'h0, 1'b0);
    access(1'b0, 20'hB0000, 4'hF, 32'h0);
    chk("R10 outside read", last_rd, 32'hFFFFFFFF);
    chk("R10 outside no strobe", vm_n - vm_base + rf_n - rf_base, 0);
    access(1'b1, 20'hAFFFE, 4'hF, 32'hDDCCBBAA);
    chk("R10 edge write count", vm_n - vm_base, 2);
    chk("R2 R8 64K address", {12'd0, vm_la[vm_base % 64]}, 32'h2BFFE);
    chk("R2 R8 64K address hi", {12'd0, vm_la[(vm_base + 1) % 64]}, 32'h2BFFF);
    chk("R9 edge data", {24'd0, vm_ld[(vm_base + 1) % 64]}, 32'hBB);
  endtask

  task automatic t_map32b0();
    set_cfg(2'b10, 4'h0, 1'b0);
    access(1'b0, 20'hB7FFC, 4'hF, 32'h0);
    chk("R2 32K B0 address", {12'd0, vm_la[vm_base % 64]}, 32'h17FFC);
    chk("R2 R9 32K B0 read order", last_rd, 32'h3C3D3E3F);
  endtask

  task automatic t_map32b8();
    set_cfg(2'b11, 4'h0, 1'b0);
    chk("R6 ovl on B8 window", {31'd0, ovl_flag}, 32'd1);
    access(1'b1, 20'hB8010, 4'b0001, 32'h0000005A);
    chk("R2 B8 window write count", vm_n - vm_base, 1);
    chk("R2 R8 B8 address", {12'd0, vm_la[vm_base % 64]}, 32'h10010);
    chk("R4 no reg when disabled", rf_n - rf_base, 0);
  endtask

  task automatic t_regs();
    set_cfg(2'b11, 4'h0, 1'b1);
    access(1'b1, 20'hB8020, 4'hF, 32'h87654321);
    chk("R4 reg write count", rf_n - rf_base, 4);
    chk("R4 no vm on page", vm_n - vm_base, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R4 reg offset", {24'd0, rf_lo[(rf_base + i) % 64]}, 32'h20 + i);
      chk("R9 reg write byte", {24'd0, rf_ld[(rf_base + i) % 64]},
          {24'd0, 8'(32'h87654321 >> (8 * i))});
    end
    chk("R4 reg write flag", {31'd0, rf_lw[rf_base % 64]}, 32'd1);
    access(1'b0, 20'hB803E, 4'hF, 32'h0);
    chk("R5 status read", last_rd, 32'hFF00FFFF);
  endtask

  task automatic t_overlap();
    set_cfg(2'b11, 4'h0, 1'b1);
    access(1'b0, 20'hB80FE, 4'hF, 32'h0);
    chk("R7 overlap spill count", vm_n - vm_base, 2);
    chk("R7 overlap spill address", {12'd0, vm_la[vm_base % 64]}, 32'h10100);
    chk("R7 overlap read data", last_rd, 32'hC2C3FFFF);
    set_cfg(2'b00, 4'h0, 1'b1);
    chk("R6 ovl cleared on remap", {31'd0, ovl_flag}, 32'd0);
    access(1'b1, 20'hB80FE, 4'hF, 32'h44332211);
    chk("R7 no spill without overlap", vm_n - vm_base, 0);
    chk("R7 page bytes still written", rf_n - rf_base, 2);
    access(1'b0, 20'hB80FE, 4'hF, 32'h0);
    chk("R7 spill reads ones", last_rd, 32'hFFFFFFFF);
    set_cfg(2'b01, 4'h0, 1'b1);
    access(1'b0, 20'hB8040, 4'b0001, 32'h0);
    chk("R4 R5 page outside window", last_rd, 32'hFFFFFF00);
  endtask

  task automatic t_linear();
    set_cfg(2'b11, 4'b0010, 1'b1);
    chk("R3 legacy inactive", {31'd0, legacy_active}, 32'd0);
    chk("R6 ovl off in linear", {31'd0, ovl_flag}, 32'd0);
    access(1'b0, 20'hB8000, 4'hF, 32'h0);
    chk("R3 linear read ones", last_rd, 32'hFFFFFFFF);
    access(1'b1, 20'hB8040, 4'hF, 32'h12345678);
    chk("R3 linear no strobes", vm_n - vm_base + rf_n - rf_base, 0);
    set_cfg(2'b11, 4'h0, 1'b1);
    chk("R3 legacy restored", {31'd0, legacy_active}, 32'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map128();
    t_map64();
    t_map32b0();
    t_map32b8();
    t_regs();
    t_overlap();
    t_linear();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule